// File: doc/BRIEF.md
# UART Receive Buffer with FIFO Status

This block sits between a UART deserializer and the register file of the UART. Each received byte, and each line-break event, is stored either in a circular FIFO or, when FIFO mode is turned off, in a single holding register. A read strobe on the data port returns the oldest byte and removes it. A packed status word reports occupancy, a full flag and a pending-overrun flag. A four-bit error status word collects overrun, parity, frame and break events and clears when it is read. Two one-cycle pulses, one for received data and one for errors, feed an interrupt controller outside the block.

Software controls the block through an 8-bit control register written on `cfg_wr`. Bit 0 turns FIFO mode on, bit 1 empties the FIFO and never reads back as 1, and bits [6:4] hold a receive trigger level that is stored and read back for the interrupt logic outside. A break event enters the FIFO as a 0x00 byte.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset the control register, the status word, the error status, data-ready and both pulses are all zero.
- R2: A control write stores the written byte with bit 1 forced to 0. When bit 1 of the written byte is 1, the FIFO is emptied at that edge and the status word reads zero on the next cycle.
- R3: With FIFO mode on (control bit 0 = 1), reads return bytes in arrival order, one per read strobe, and data-ready stays 1 only while at least one entry remains.
- R4: The status word holds the occupancy in bits [7:0], the full flag in bit 8 and the pending-overrun flag (error status bit 0) in bit 9. While the FIFO is full, bits [7:0] read 0.
- R5: A read strobe with FIFO mode on and the FIFO empty returns 0 on `rd_data` and produces an error pulse on the next cycle.
- R6: A byte or break arriving while the FIFO is full is dropped. It sets overrun (error status bit 0) and produces an error pulse on the next cycle.
- R7: Every accepted byte produces a receive pulse on the cycle after its arrival.
- R8: With FIFO mode off, an arriving byte overwrites the holding register and sets data-ready. A read returns the holding register and clears data-ready.
- R9: A break event stores 0x00 and sets break (error status bit 3).
- R10: The error status is overrun (bit 0), parity (bit 1), frame (bit 2) and break (bit 3). Parity and frame are set by an accepted byte flagged with `rx_perr` or `rx_ferr`. A read strobe on `err_rd` clears the whole word at that edge.
- R11: A push and a pop in the same cycle on a FIFO that is neither empty nor full leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_q | output | 8 | Control register contents |
| rx_valid | input | 1 | A received byte is present |
| rx_byte | input | DATA_W | Received byte |
| rx_perr | input | 1 | Parity error flag for rx_byte |
| rx_ferr | input | 1 | Frame error flag for rx_byte |
| rx_break | input | 1 | Line-break event (takes priority over rx_valid) |
| rd_data_en | input | 1 | Data register read strobe |
| rd_data | output | DATA_W | Value returned by a read in this cycle |
| err_rd | input | 1 | Error status read strobe (clears it) |
| err_stat | output | 4 | Error status word |
| fifo_stat | output | 10 | Packed FIFO status word |
| data_ready | output | 1 | Data available to read |
| rx_irq | output | 1 | Receive interrupt-source pulse |
| err_irq | output | 1 | Error interrupt-source pulse |

## Verification
The bench builds the block with DEPTH = 4 and the default 8-bit data width. With that depth, filling the FIFO takes four pushes. This puts the full-status encoding, a dropped fifth byte and pointer wrap-around within a few dozen cycles. It also leaves room for a same-cycle push and pop on a partly filled FIFO, and for a reset strobe while the FIFO holds data.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
   localparam int CTRL_W   = 8;
   localparam int STAT_W   = 10;
   localparam int ERR_W    = 4;
   // control register bit positions (decoded by this block)
   localparam int FEN_BIT  = 0;
   localparam int CLR_BIT  = 1;
   // error status bit positions
   localparam int ERR_OVR  = 0;
   localparam int ERR_PAR  = 1;
   localparam int ERR_FRM  = 2;
   localparam int ERR_BRK  = 3;
   // status word bit positions
   localparam int ST_FULL  = 8;
   localparam int ST_OVR   = 9;
endpackage

// File: rtl/rxb_ctrl.sv
module rxb_ctrl
   import rxb_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [CTRL_W-1:0] wdata,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic              fifo_clr
);
   localparam logic [CTRL_W-1:0] KEEP_MASK = ~(CTRL_W'(1) << CLR_BIT);

   assign fifo_clr = wr & wdata[CLR_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ctrl_q <= '0;
      else if (wr) ctrl_q <= wdata & KEEP_MASK;
   end
endmodule

// File: rtl/rxb_fifo.sv
module rxb_fifo #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              push,
   input  logic [DATA_W-1:0] din,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic [CNT_W-1:0]  count,
   output logic              full,
   output logic              empty
);
   logic [PTR_W-1:0]  wptr, rptr;
   logic [DATA_W-1:0] mem [DEPTH];

   assign full  = (count == CNT_W'(DEPTH));
   assign empty = (count == '0);
   assign head  = mem[rptr];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mem[i] <= '0;
            else if (push && !clr && wptr == PTR_W'(i))
               mem[i] <= din;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else if (clr) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push) wptr <= wptr + 1'b1;
         if (pop)  rptr <= rptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/rxb_errs.sv
module rxb_errs
   import rxb_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd,
   input  logic [ERR_W-1:0] set,
   output logic [ERR_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (rd ? '0 : q) | set;
   end
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
   import rxb_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_q,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              rx_perr,
   input  logic              rx_ferr,
   input  logic              rx_break,
   input  logic              rd_data_en,
   output logic [DATA_W-1:0] rd_data,
   input  logic              err_rd,
   output logic [3:0]        err_stat,
   output logic [9:0]        fifo_stat,
   output logic              data_ready,
   output logic              rx_irq,
   output logic              err_irq
);
   localparam int CNT_W = $clog2(DEPTH) + 1;

   generate
      if (DEPTH < 2 || DEPTH > 128 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two between 2 and 128");
      end
      if (DATA_W < 1 || DATA_W > 8) begin : g_bad_width
         $error("DATA_W must lie between 1 and 8");
      end
   endgenerate

   logic              fifo_clr, fen, arrive, accepted;
   logic              f_push_req, f_push, f_pop, f_drop, empty_rd;
   logic              f_full, f_empty;
   logic [CNT_W-1:0]  f_count;
   logic [DATA_W-1:0] f_head, in_byte, hold_q;
   logic              hold_rdy;
   logic [ERR_W-1:0]  err_set;

   rxb_ctrl u_ctrl (
      .clk, .rst_n, .wr(cfg_wr), .wdata(cfg_wdata),
      .ctrl_q(cfg_q), .fifo_clr(fifo_clr)
   );

   assign fen        = cfg_q[FEN_BIT];
   assign arrive     = rx_valid | rx_break;
   assign in_byte    = rx_break ? '0 : rx_byte;
   assign f_push_req = arrive & fen & ~fifo_clr;
   assign f_drop     = f_push_req & f_full;
   assign f_push     = f_push_req & ~f_full;
   assign f_pop      = rd_data_en & fen & ~f_empty & ~fifo_clr;
   assign empty_rd   = rd_data_en & fen & f_empty;
   assign accepted   = f_push | (arrive & ~fen);

   rxb_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
      .clk, .rst_n, .clr(fifo_clr), .push(f_push), .din(in_byte),
      .pop(f_pop), .head(f_head), .count(f_count),
      .full(f_full), .empty(f_empty)
   );

   // single holding register used when FIFO mode is off
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q   <= '0;
         hold_rdy <= 1'b0;
      end else if (arrive && !fen) begin
         hold_q   <= in_byte;
         hold_rdy <= 1'b1;
      end else if (rd_data_en && !fen) begin
         hold_rdy <= 1'b0;
      end
   end

   always_comb begin
      err_set          = '0;
      err_set[ERR_OVR] = f_drop;
      err_set[ERR_PAR] = accepted & ~rx_break & rx_perr;
      err_set[ERR_FRM] = accepted & ~rx_break & rx_ferr;
      err_set[ERR_BRK] = rx_break;
   end

   rxb_errs u_errs (
      .clk, .rst_n, .rd(err_rd), .set(err_set), .q(err_stat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_irq  <= 1'b0;
         err_irq <= 1'b0;
      end else begin
         rx_irq  <= accepted;
         err_irq <= f_drop | empty_rd;
      end
   end

   assign rd_data    = fen ? (f_empty ? '0 : f_head) : hold_q;
   assign data_ready = fen ? ~f_empty : hold_rdy;
   assign fifo_stat  = {err_stat[ERR_OVR], f_full, (f_full ? 8'h00 : 8'(f_count))};
endmodule

// File: rtl/uart_rx_buffer_chk.sv
module uart_rx_buffer_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr,
   input logic [7:0]        cfg_wdata,
   input logic [7:0]        cfg_q,
   input logic              rx_valid,
   input logic              rx_break,
   input logic              rd_data_en,
   input logic [DATA_W-1:0] rd_data,
   input logic              err_rd,
   input logic [3:0]        err_stat,
   input logic [9:0]        fifo_stat,
   input logic              data_ready,
   input logic              rx_irq,
   input logic              err_irq
);
   // R4
   full_cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_stat[8] |-> fifo_stat[7:0] == 8'h00);

   // R5
   empty_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data_en && cfg_q[0] && !data_ready) |-> rd_data == '0);

   // R5
   empty_rd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data_en && cfg_q[0] && !data_ready) |=> err_irq);

   // R2
   clr_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_q[1]);

   // R2
   clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_wdata[1]) |=> fifo_stat[8:0] == 9'h000);

   // R6
   drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((rx_valid || rx_break) && cfg_q[0] && fifo_stat[8] && !cfg_wr) |=> (err_irq && err_stat[0]));

   // R10
   err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_rd && !rx_valid && !rx_break) |=> err_stat == 4'h0);

   // R11
   push_pop_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_break && cfg_q[0] && rd_data_en && data_ready && !fifo_stat[8] && !cfg_wr)
      |=> $stable(fifo_stat[8:0]));

   // R7
   hold_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !cfg_q[0] && !cfg_wr) |=> (rx_irq && data_ready));
endmodule

bind uart_rx_buffer uart_rx_buffer_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_uart_rx_buffer.sv
`timescale 1ns/100ps
module sim_uart_rx_buffer;
   localparam int DEPTH = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_q;
   logic       rx_valid = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0, rx_break = 1'b0;
   logic [7:0] rx_byte = '0;
   logic       rd_data_en = 1'b0, err_rd = 1'b0;
   logic [7:0] rd_data;
   logic [3:0] err_stat;
   logic [9:0] fifo_stat;
   logic       data_ready, rx_irq, err_irq;

   int n_chk = 0, n_fail = 0;
   bit m_fen = 0;
   int m_cnt = 0;
   logic [7:0] exp_q [$];
   logic [7:0] v;

   always #2.5 clk = ~clk;

   uart_rx_buffer #(.DEPTH(DEPTH), .DATA_W(8)) u0 (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // driver: presents one arrival and records what the scoreboard expects
   task automatic send(input logic [7:0] b, input bit brk, input bit pe, input bit fe);
      @(negedge clk);
      rx_valid = !brk; rx_break = brk; rx_byte = b; rx_perr = pe; rx_ferr = fe;
      if (m_fen && m_cnt < DEPTH) begin
         exp_q.push_back(brk ? 8'h00 : b);
         m_cnt++;
      end
      @(negedge clk);
      rx_valid = 0; rx_break = 0; rx_perr = 0; rx_ferr = 0;
   endtask

   // monitor: reads one value and compares it with the scoreboard
   task automatic read_cmp(input string req);
      logic [7:0] e;
      @(negedge clk);
      rd_data_en = 1;
      #1;
      if (m_fen && m_cnt > 0) begin
         e = exp_q.pop_front();
         m_cnt--;
      end else e = 8'h00;
      chk(req, rd_data, e);
      @(negedge clk);
      rd_data_en = 0;
   endtask

   task automatic cfg(input logic [7:0] b);
      @(negedge clk);
      cfg_wr = 1; cfg_wdata = b;
      m_fen = b[0];
      if (b[1]) begin exp_q.delete(); m_cnt = 0; end
      @(negedge clk);
      cfg_wr = 0;
   endtask

   task automatic read_err(output logic [7:0] r);
      @(negedge clk);
      r = {4'h0, err_stat};
      err_rd = 1;
      @(negedge clk);
      err_rd = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 status", fifo_stat, 0);
      chk("R1 ready", data_ready, 0);
      chk("R1 ctrl", cfg_q, 0);
      chk("R1 err", err_stat, 0);
      chk("R1 pulses", {rx_irq, err_irq}, 0);
      rst_n = 1;

      // R8 holding register with FIFO mode off
      send(8'h5A, 0, 0, 0);
      chk("R7 rx pulse", rx_irq, 1);
      chk("R8 ready set", data_ready, 1);
      @(negedge clk);
      rd_data_en = 1; #1;
      chk("R8 hold data", rd_data, 8'h5A);
      @(negedge clk);
      rd_data_en = 0;
      chk("R8 ready cleared", data_ready, 0);

      // R2 control register storage, trigger bits kept
      cfg(8'h51);
      chk("R2 ctrl store", cfg_q, 8'h51);

      // R3 ordering
      send(8'h11, 0, 0, 0);
      send(8'h22, 0, 0, 0);
      send(8'h33, 0, 0, 0);
      chk("R4 count", fifo_stat, 10'h003);
      read_cmp("R3 order");
      chk("R3 ready while entries", data_ready, 1);
      read_cmp("R3 order");
      read_cmp("R3 order");
      chk("R3 ready drops", data_ready, 0);

      // R4 full, R6 overflow drop
      for (int i = 0; i < DEPTH; i++) send(8'hA0 + 8'(i), 0, 0, 0);
      chk("R4 full encoding", fifo_stat, 10'h100);
      send(8'hEE, 0, 0, 0);
      chk("R6 err pulse", err_irq, 1);
      chk("R6 overrun in status", fifo_stat, 10'h300);
      read_err(v);
      chk("R10 overrun read", v, 8'h01);
      chk("R10 cleared", err_stat, 0);
      for (int i = 0; i < DEPTH; i++) read_cmp("R6 dropped byte absent");

      // R5 empty read
      read_cmp("R5 empty read zero");
      chk("R5 err pulse", err_irq, 1);

      // R9 break
      send(8'h77, 1, 0, 0);
      chk("R9 break count", fifo_stat, 10'h001);
      chk("R9 break flag", err_stat, 4'h8);
      read_cmp("R9 null byte");
      read_err(v);

      // R10 parity and frame
      send(8'h44, 0, 1, 0);
      chk("R10 parity", err_stat, 4'h2);
      send(8'h45, 0, 0, 1);
      chk("R10 frame", err_stat, 4'h6);
      read_cmp("R10 data");
      read_cmp("R10 data");
      read_err(v);
      chk("R10 read value", v, 8'h06);

      // R11 simultaneous push and pop (wrapped pointers)
      send(8'h61, 0, 0, 0);
      @(negedge clk);
      rx_valid = 1; rx_byte = 8'h62; rd_data_en = 1;
      #1;
      chk("R11 head", rd_data, 8'h61);
      @(negedge clk);
      rx_valid = 0; rd_data_en = 0;
      void'(exp_q.pop_front());
      exp_q.push_back(8'h62);
      chk("R11 count kept", fifo_stat, 10'h001);
      read_cmp("R11 pushed byte");

      // R2 reset bit empties the FIFO and clears itself
      send(8'h71, 0, 0, 0);
      send(8'h72, 0, 0, 0);
      cfg(8'h53);
      chk("R2 emptied", fifo_stat, 10'h000);
      chk("R2 self clear", cfg_q, 8'h51);
      chk("R2 ready low", data_ready, 0);
      send(8'h73, 0, 0, 0);
      read_cmp("R2 after clear");

      finish_run();
   end
endmodule